// File: doc/BRIEF.md
# Bus Slave Register Bank for a Readout Board

This block is the register-level front end that a bus master uses to set up and watch a data acquisition board. It sits behind a simplified single-cycle bus with 24-bit addressing and 32-bit data. It claims an access only when the address modifier is one of the four standard data codes and the upper sixteen address bits equal a base address. That base address is set by four 4-bit switch inputs. Inside its 256-byte window it serves four locations:

- a parameter register that holds the static acquisition settings;
- a control/status word, where a bit can mean one thing on write and another on read;
- a reset register;
- a data port onto the capture FIFO.

Writing the reset register can produce a one-cycle module reset. That reset clears every register of the block and is also sent out to clear the counters and FIFO pointers elsewhere. The same register also holds a level reset for the clock/trigger receiver: software asserts it by writing a one and releases it by writing a zero.

The block passes on a software trigger pulse and the external-trigger disable level. It also collects the busy flag, receiver-ready flag, trigger count and FIFO state into a single status word. While acquisition is busy, the FIFO data port refuses every access and never acknowledges it, so the master's own timeout ends the cycle. The three control locations keep working during busy.

Top module: `vme_regbank`

## Requirements
- R1: An access is acknowledged only if `am` is 0x39, 0x3A, 0x3D or 0x3E. Any other modifier gets no acknowledge and causes no side effect.
- R2: `addr[23:8]` must equal `{base_n3, base_n2, base_n1, base_n0}` (base_n3 compared with addr[23:20]). A mismatch in any single bit gets no acknowledge.
- R3: Within the window, offsets 0x00 (parameters), 0x04 (control/status), 0x08 (reset) and 0x10 (FIFO port) are acknowledged. Every other value of `addr[7:0]` is not.
- R4: The parameter register has these fields: clock delay [4:0], trigger delay [7:5], mode [9:8], low limit [23:16] and high limit [31:24]. Each field is written, read back and driven on its own output port. Bits [11:10] read 0. Bits [13:12] read the REVISION parameter and bits [15:14] read the VERSION parameter, and writes to either field are ignored.
- R5: Writing the control word with bit 0 = 1 gives a one-cycle `sw_trig` pulse. Bit 2 is the external-trigger disable: it is writable, drives `ext_trig_dis` and reads back in bit 2. On read, bit 0 returns `busy` and bit 1 returns `rx_ready`.
- R6: The control word reads back the following. `trig_cnt` appears in [15:4], `fifo_full` in [16], `fifo_empty` in [17] and `fifo_cnt` in [31:20]. Bits [3] and [19:18] read 0.
- R7: Writing the reset register with bit 0 = 1 gives a one-cycle `mod_rst` pulse. In the next cycle all parameter fields and the trigger disable are zero.
- R8: Writing the reset register with bit 1 = 1 sets `rx_rst`. It stays set through other accesses until the reset register is written with bit 1 = 0. Reading the reset register returns `rx_rst` in bit 1.
- R9: While `busy` is 1, an access to the FIFO port gets no acknowledge and no `fifo_rd` or `fifo_wr` strobe. The other three locations are still acknowledged.
- R10: An accepted access is acknowledged by `ack` one cycle after acceptance. The acknowledge lasts exactly one cycle, and read data is valid on `rdata` while `ack` is high.
- R11: A FIFO port read returns `fifo_rdata` (channel 0 in [7:0] through channel 3 in [31:24]) and gives a one-cycle `fifo_rd`. A FIFO port write gives a one-cycle `fifo_wr` with `fifo_wdata` equal to the written word.
- R12: After power-on reset there is no acknowledge and no strobe, `rx_rst` is 0, and all parameter outputs and `ext_trig_dis` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| base_n3 | input | 4 | Base address switch for addr[23:20] |
| base_n2 | input | 4 | Base address switch for addr[19:16] |
| base_n1 | input | 4 | Base address switch for addr[15:12] |
| base_n0 | input | 4 | Base address switch for addr[11:8] |
| req | input | 1 | Access request, held until ack or master timeout |
| wr | input | 1 | 1 = write, 0 = read |
| am | input | 6 | Address modifier |
| addr | input | 24 | Byte address |
| wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle acknowledge |
| rdata | output | 32 | Read data, valid with ack |
| busy | input | 1 | Acquisition in progress |
| rx_ready | input | 1 | Clock/trigger receiver ready |
| trig_cnt | input | 12 | Trigger counter value |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_cnt | input | 12 | FIFO word count |
| fifo_rdata | input | 32 | FIFO head word, four packed 8-bit samples |
| fifo_rd | output | 1 | FIFO pop strobe |
| fifo_wr | output | 1 | FIFO push strobe |
| fifo_wdata | output | 32 | FIFO push data |
| clk_dly | output | 5 | Sampling clock delay code |
| trig_dly | output | 3 | External trigger delay in cycles |
| mode | output | 2 | Operating mode |
| lo_lim | output | 8 | Low-level limit |
| hi_lim | output | 8 | High-level limit |
| ext_trig_dis | output | 1 | External trigger disable |
| sw_trig | output | 1 | Software trigger pulse |
| mod_rst | output | 1 | Module reset pulse |
| rx_rst | output | 1 | Receiver reset level |

## Verification
The assertions assume a master that has at most one access outstanding. That master holds `req`, `wr`, `am`, `addr` and `wdata` steady from the first request cycle until it sees `ack` or abandons the access, and it drops `req` right after the acknowledge. With that assumption, the modifier and offset sampled one cycle before `ack` identify the accepted access. The bench keeps to this rule: each access is issued alone, inputs change only on the falling edge, `req` is released in the cycle `ack` is seen, and an unacknowledged request is withdrawn after a fixed window. `busy` and the status inputs change only between accesses.

// File: rtl/vme_regbank_pkg.sv
package vme_regbank_pkg;

  localparam int unsigned ADDR_W = 24;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFS_W  = 8;
  localparam int unsigned BASE_W = ADDR_W - OFS_W;
  localparam int unsigned CNT_W  = 12;

  localparam logic [OFS_W-1:0] OFS_PARAM = 8'h00;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 8'h04;
  localparam logic [OFS_W-1:0] OFS_RST   = 8'h08;
  localparam logic [OFS_W-1:0] OFS_FIFO  = 8'h10;

  typedef enum logic [1:0] {
    SEL_PARAM = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_RST   = 2'd2,
    SEL_FIFO  = 2'd3
  } sel_e;

  // packed in register bit order, reserved/read-only bits excluded
  typedef struct packed {
    logic [7:0] hi_lim;
    logic [7:0] lo_lim;
    logic [1:0] mode;
    logic [2:0] trig_dly;
    logic [4:0] clk_dly;
  } param_t;

  function automatic logic am_accepted(input logic [5:0] code);
    return (code == 6'h39) || (code == 6'h3A) ||
           (code == 6'h3D) || (code == 6'h3E);
  endfunction

endpackage

// File: rtl/vme_addr_decode.sv
module vme_addr_decode
  import vme_regbank_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned OW = OFS_W
) (
  input  logic              req,
  input  logic [5:0]        am,
  input  logic [AW-1:0]     addr,
  input  logic [AW-OW-1:0]  base,
  output logic              hit,
  output sel_e              sel
);

  logic          base_ok;
  logic          ofs_ok;
  logic [OW-1:0] ofs;

  assign ofs     = addr[OW-1:0];
  assign base_ok = (addr[AW-1:OW] == base);

  always_comb begin
    ofs_ok = 1'b1;
    sel    = SEL_PARAM;
    unique case (ofs)
      OFS_PARAM: sel = SEL_PARAM;
      OFS_CTRL:  sel = SEL_CTRL;
      OFS_RST:   sel = SEL_RST;
      OFS_FIFO:  sel = SEL_FIFO;
      default:   ofs_ok = 1'b0;
    endcase
  end

  assign hit = req && am_accepted(am) && base_ok && ofs_ok;

endmodule

// File: rtl/vme_param_reg.sv
module vme_param_reg
  import vme_regbank_pkg::*;
(
  input  logic         clk,
  input  logic         rst_i,
  input  logic         we,
  input  param_t       din,
  output param_t       q
);

  always_ff @(posedge clk) begin
    if (rst_i) begin
      q <= '0;
    end else if (we) begin
      q <= din;
    end
  end

endmodule

// File: rtl/vme_reset_gen.sv
module vme_reset_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] din,
  output logic       mod_rst,
  output logic       rx_rst
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_rst <= 1'b0;
      rx_rst  <= 1'b0;
    end else begin
      mod_rst <= we && din[0];
      if (we) begin
        rx_rst <= din[1];
      end
    end
  end

endmodule

// File: rtl/vme_regbank.sv
module vme_regbank
  import vme_regbank_pkg::*;
#(
  parameter logic [1:0] REVISION = 2'd3,
  parameter logic [1:0] VERSION  = 2'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        base_n3,
  input  logic [3:0]        base_n2,
  input  logic [3:0]        base_n1,
  input  logic [3:0]        base_n0,
  input  logic              req,
  input  logic              wr,
  input  logic [5:0]        am,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  input  logic              rx_ready,
  input  logic [CNT_W-1:0]  trig_cnt,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic [CNT_W-1:0]  fifo_cnt,
  input  logic [DATA_W-1:0] fifo_rdata,
  output logic              fifo_rd,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic [4:0]        clk_dly,
  output logic [2:0]        trig_dly,
  output logic [1:0]        mode,
  output logic [7:0]        lo_lim,
  output logic [7:0]        hi_lim,
  output logic              ext_trig_dis,
  output logic              sw_trig,
  output logic              mod_rst,
  output logic              rx_rst
);

  logic [BASE_W-1:0] base;
  logic              hit;
  sel_e              sel;
  logic              acc;
  logic              rst_i;
  param_t            prm;
  logic [DATA_W-1:0] rd_mux;

  assign base  = {base_n3, base_n2, base_n1, base_n0};
  assign rst_i = rst | mod_rst;

  vme_addr_decode i_dec (
    .req  (req),
    .am   (am),
    .addr (addr),
    .base (base),
    .hit  (hit),
    .sel  (sel)
  );

  // FIFO port refused while busy; one access per acknowledge
  assign acc = hit && !ack && !((sel == SEL_FIFO) && busy);

  vme_param_reg i_prm (
    .clk   (clk),
    .rst_i (rst_i),
    .we    (acc && wr && (sel == SEL_PARAM)),
    .din   ({wdata[31:16], wdata[9:0]}),
    .q     (prm)
  );

  vme_reset_gen i_rst (
    .clk     (clk),
    .rst     (rst),
    .we      (acc && wr && (sel == SEL_RST)),
    .din     (wdata[1:0]),
    .mod_rst (mod_rst),
    .rx_rst  (rx_rst)
  );

  always_comb begin
    unique case (sel)
      SEL_PARAM: rd_mux = {prm.hi_lim, prm.lo_lim, VERSION, REVISION, 2'b00,
                           prm.mode, prm.trig_dly, prm.clk_dly};
      SEL_CTRL:  rd_mux = {fifo_cnt, 2'b00, fifo_empty, fifo_full, trig_cnt,
                           1'b0, ext_trig_dis, rx_ready, busy};
      SEL_RST:   rd_mux = {{(DATA_W-2){1'b0}}, rx_rst, 1'b0};
      SEL_FIFO:  rd_mux = fifo_rdata;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      ack          <= 1'b0;
      rdata        <= '0;
      sw_trig      <= 1'b0;
      ext_trig_dis <= 1'b0;
      fifo_rd      <= 1'b0;
      fifo_wr      <= 1'b0;
      fifo_wdata   <= '0;
    end else begin
      ack     <= acc;
      sw_trig <= acc && wr && (sel == SEL_CTRL) && wdata[0];
      fifo_rd <= acc && !wr && (sel == SEL_FIFO);
      fifo_wr <= acc && wr && (sel == SEL_FIFO);
      if (acc && wr && (sel == SEL_CTRL)) begin
        ext_trig_dis <= wdata[2];
      end
      if (acc && wr && (sel == SEL_FIFO)) begin
        fifo_wdata <= wdata;
      end
      if (acc && !wr) begin
        rdata <= rd_mux;
      end
    end
  end

  assign clk_dly  = prm.clk_dly;
  assign trig_dly = prm.trig_dly;
  assign mode     = prm.mode;
  assign lo_lim   = prm.lo_lim;
  assign hi_lim   = prm.hi_lim;

endmodule

// File: rtl/vme_regbank_chk.sv
module vme_regbank_chk (
  input logic       clk,
  input logic       rst,
  input logic       req,
  input logic       wr,
  input logic [5:0] am,
  input logic [7:0] ofs,
  input logic [1:0] wd_lo,
  input logic       busy,
  input logic       ack,
  input logic       mod_rst,
  input logic       rx_rst,
  input logic       fifo_rd,
  input logic       fifo_wr,
  input logic [4:0] clk_dly,
  input logic [1:0] mode,
  input logic [7:0] hi_lim
);

  AST_AM_FILTER: assert property (@(posedge clk) disable iff (rst)
    ack |-> ($past(am) == 6'h39 || $past(am) == 6'h3A ||
             $past(am) == 6'h3D || $past(am) == 6'h3E));  // R1

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);  // R10

  AST_BUSY_NO_POP: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> !$past(busy));  // R9

  AST_BUSY_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> !$past(busy));  // R9

  AST_BUSY_FIFO_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    ack |-> !($past(busy) && $past(ofs) == 8'h10));  // R9

  AST_MODRST_PULSE: assert property (@(posedge clk) disable iff (rst)
    mod_rst |=> !mod_rst);  // R7

  AST_MODRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(mod_rst) |-> (clk_dly == 5'd0 && mode == 2'd0 && hi_lim == 8'd0));  // R7

  AST_RXRST_SET_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_rst) |-> $past(req && wr && ofs == 8'h08 && wd_lo[1]));  // R8

  AST_RXRST_CLR_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_rst) |-> $past(req && wr && ofs == 8'h08 && !wd_lo[1]));  // R8

endmodule

bind vme_regbank vme_regbank_chk i_chk (
  .clk     (clk),
  .rst     (rst),
  .req     (req),
  .wr      (wr),
  .am      (am),
  .ofs     (addr[7:0]),
  .wd_lo   (wdata[1:0]),
  .busy    (busy),
  .ack     (ack),
  .mod_rst (mod_rst),
  .rx_rst  (rx_rst),
  .fifo_rd (fifo_rd),
  .fifo_wr (fifo_wr),
  .clk_dly (clk_dly),
  .mode    (mode),
  .hi_lim  (hi_lim)
);

// File: tb/test_vme_regbank.sv
module test_vme_regbank;

  localparam logic [1:0] REV = 2'd3;
  localparam logic [1:0] VER = 2'd1;
  localparam logic [15:0] BASE = 16'hA5C3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, wr = 1'b0;
  logic [5:0] am = 6'h39;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0;
  logic ack;
  logic [31:0] rdata;
  logic busy = 1'b0, rx_ready = 1'b0, fifo_full = 1'b0, fifo_empty = 1'b0;
  logic [11:0] trig_cnt = '0, fifo_cnt = '0;
  logic [31:0] fifo_rdata = '0;
  logic fifo_rd, fifo_wr;
  logic [31:0] fifo_wdata;
  logic [4:0] clk_dly;
  logic [2:0] trig_dly;
  logic [1:0] mode;
  logic [7:0] lo_lim, hi_lim;
  logic ext_trig_dis, sw_trig, mod_rst, rx_rst;

  int errors = 0;
  int checks = 0;
  bit seen_rd, seen_wr, seen_trig, seen_mrst;

  always #5 clk = ~clk;

  vme_regbank #(.REVISION(REV), .VERSION(VER)) i_vme_regbank (
    .clk(clk), .rst(rst),
    .base_n3(BASE[15:12]), .base_n2(BASE[11:8]),
    .base_n1(BASE[7:4]), .base_n0(BASE[3:0]),
    .req(req), .wr(wr), .am(am), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata),
    .busy(busy), .rx_ready(rx_ready), .trig_cnt(trig_cnt),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_cnt(fifo_cnt),
    .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .clk_dly(clk_dly), .trig_dly(trig_dly),
    .mode(mode), .lo_lim(lo_lim), .hi_lim(hi_lim),
    .ext_trig_dis(ext_trig_dis), .sw_trig(sw_trig),
    .mod_rst(mod_rst), .rx_rst(rx_rst)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  // one bus access; window of 5 cycles, strobes accumulated over it
  task automatic access(input bit w, input logic [5:0] m, input logic [23:0] a,
                        input logic [31:0] d, output bit got, output logic [31:0] q);
    @(negedge clk);
    req = 1'b1; wr = w; am = m; addr = a; wdata = d;
    got = 1'b0; q = '0;
    seen_rd = 0; seen_wr = 0; seen_trig = 0; seen_mrst = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      seen_rd   |= fifo_rd;
      seen_wr   |= fifo_wr;
      seen_trig |= sw_trig;
      seen_mrst |= mod_rst;
      if (ack && !got) begin
        got = 1'b1;
        q = rdata;
        req = 1'b0;
      end
    end
    req = 1'b0;
  endtask

  function automatic logic [23:0] ad(input logic [7:0] o);
    return {BASE, o};
  endfunction

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit g;
    logic [31:0] q;
    logic [31:0] p;
    logic [31:0] exp;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check("R12 ack", {31'b0, ack}, 32'd0);
    check("R12 rx_rst", {31'b0, rx_rst}, 32'd0);
    check("R12 params", {5'b0, hi_lim, lo_lim, mode, trig_dly, clk_dly, ext_trig_dis}, 32'd0);
    check("R12 strobes", {28'b0, fifo_rd, fifo_wr, sw_trig, mod_rst}, 32'd0);

    // R1 modifier sweep
    for (int m = 0; m < 64; m++) begin
      access(1'b0, m[5:0], ad(8'h00), 32'd0, g, q);
      check("R1 am sweep", {31'b0, g},
            {31'b0, (m == 'h39 || m == 'h3A || m == 'h3D || m == 'h3E)});
    end

    // R2 base address single-bit mismatches
    access(1'b0, 6'h3D, ad(8'h04), 32'd0, g, q);
    check("R2 base match", {31'b0, g}, 32'd1);
    for (int b = 8; b < 24; b++) begin
      access(1'b0, 6'h3D, ad(8'h04) ^ (24'd1 << b), 32'd0, g, q);
      check("R2 base mismatch", {31'b0, g}, 32'd0);
    end

    // R3 offset sweep
    for (int o = 0; o < 256; o++) begin
      access(1'b0, 6'h3A, ad(o[7:0]), 32'd0, g, q);
      check("R3 offset", {31'b0, g},
            {31'b0, (o == 'h00 || o == 'h04 || o == 'h08 || o == 'h10)});
    end

    // R4 parameter patterns
    foreach (p[i]) begin end
    for (int k = 0; k < 6; k++) begin
      p = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h0000_0000 :
          (k == 2) ? 32'hA55A_3C3C : (k == 3) ? 32'h1234_F2AB :
          (k == 4) ? 32'h8001_0321 : 32'h7E81_C0DE;
      access(1'b1, 6'h39, ad(8'h00), p, g, q);
      check("R10 write ack", {31'b0, g}, 32'd1);
      access(1'b0, 6'h39, ad(8'h00), 32'd0, g, q);
      exp = {p[31:16], VER, REV, 2'b00, p[9:0]};
      check("R4 readback", q, exp);
      check("R4 ports", {6'b0, hi_lim, lo_lim, mode, trig_dly, clk_dly},
            {6'b0, p[31:16], p[9:0]});
    end

    // R10 ack lasts one cycle
    @(negedge clk);
    req = 1'b1; wr = 1'b0; am = 6'h3E; addr = ad(8'h00);
    @(negedge clk);
    check("R10 ack after one cycle", {31'b0, ack}, 32'd1);
    req = 1'b0;
    @(negedge clk);
    check("R10 ack single", {31'b0, ack}, 32'd0);

    // R5 control
    access(1'b1, 6'h39, ad(8'h04), 32'd1, g, q);
    check("R5 sw_trig pulse", {31'b0, seen_trig}, 32'd1);
    check("R5 sw_trig ends", {31'b0, sw_trig}, 32'd0);
    access(1'b1, 6'h39, ad(8'h04), 32'd4, g, q);
    check("R5 no trig on bit0=0", {31'b0, seen_trig}, 32'd0);
    check("R5 ext_trig_dis", {31'b0, ext_trig_dis}, 32'd1);

    // R6 status patterns, also R5 read bits and R9 control access while busy
    for (int k = 0; k < 4; k++) begin
      trig_cnt = 12'h5A3 ^ (12'h111 * k[11:0]);
      fifo_cnt = 12'hC0F + 12'h0F1 * k[11:0];
      fifo_full = k[0]; fifo_empty = k[1]; busy = k[0] ^ k[1]; rx_ready = ~k[0];
      access(1'b0, 6'h3D, ad(8'h04), 32'd0, g, q);
      exp = {fifo_cnt, 2'b00, fifo_empty, fifo_full, trig_cnt, 1'b0, 1'b1, rx_ready, busy};
      check("R6 status word", q, exp);
      check("R9 ctrl ok while busy", {31'b0, g}, 32'd1);
    end
    busy = 1'b0;

    // R11 FIFO port
    fifo_rdata = {8'hD3, 8'hC2, 8'hB1, 8'hA0};
    access(1'b0, 6'h39, ad(8'h10), 32'd0, g, q);
    check("R11 fifo read data", q, 32'hD3C2B1A0);
    check("R11 fifo_rd pulse", {31'b0, seen_rd}, 32'd1);
    access(1'b1, 6'h39, ad(8'h10), 32'hCAFE_0420, g, q);
    check("R11 fifo_wr pulse", {31'b0, seen_wr}, 32'd1);
    check("R11 fifo_wdata", fifo_wdata, 32'hCAFE_0420);

    // R9 busy blocks FIFO
    busy = 1'b1;
    access(1'b0, 6'h39, ad(8'h10), 32'd0, g, q);
    check("R9 busy read no ack", {31'b0, g}, 32'd0);
    check("R9 busy no fifo_rd", {31'b0, seen_rd}, 32'd0);
    access(1'b1, 6'h39, ad(8'h10), 32'h1111_2222, g, q);
    check("R9 busy write no ack", {31'b0, g}, 32'd0);
    check("R9 busy no fifo_wr", {31'b0, seen_wr}, 32'd0);
    access(1'b1, 6'h39, ad(8'h00), 32'h0000_0155, g, q);
    check("R9 param write while busy", {24'b0, trig_dly, clk_dly}, 32'h55);
    busy = 1'b0;

    // R8 receiver reset
    access(1'b1, 6'h39, ad(8'h08), 32'd2, g, q);
    check("R8 rx_rst set", {31'b0, rx_rst}, 32'd1);
    access(1'b1, 6'h39, ad(8'h00), 32'd0, g, q);
    access(1'b0, 6'h39, ad(8'h08), 32'd0, g, q);
    check("R8 rx_rst held/readback", q, 32'd2);
    access(1'b1, 6'h39, ad(8'h08), 32'd0, g, q);
    check("R8 rx_rst cleared", {31'b0, rx_rst}, 32'd0);

    // R7 module reset
    access(1'b1, 6'h39, ad(8'h00), 32'hFFFF_FFFF, g, q);
    access(1'b1, 6'h39, ad(8'h04), 32'd4, g, q);
    access(1'b1, 6'h39, ad(8'h08), 32'd1, g, q);
    check("R7 mod_rst pulse", {31'b0, seen_mrst}, 32'd1);
    check("R7 mod_rst ends", {31'b0, mod_rst}, 32'd0);
    check("R7 params zero", {5'b0, hi_lim, lo_lim, mode, trig_dly, clk_dly, ext_trig_dis}, 32'd0);
    access(1'b0, 6'h39, ad(8'h00), 32'd0, g, q);
    check("R7 param readback", q, {16'd0, VER, REV, 12'd0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule